// File: doc/BRIEF.md
# Packed-Lane SIMD Integer ALU

This block is a 64-bit integer datapath that can treat its two operands as one wide word or as a row of narrower independent lanes. A two-bit lane-mode input picks eight 8-bit lanes, four 16-bit lanes, two 32-bit lanes or a single 64-bit lane. Every lane is then added, multiplied (keeping only the low lane-width bits of the product) or compared, and no lane sees anything from its neighbours.

Next to the packed result, the block returns its own set of condition flags for every lane: zero, sign, carry, equal and less-than. Each flag vector is eight bits wide, with one bit per byte position. In the wider modes a lane's flag is copied onto every byte position that the lane covers, so later logic can read the flags without knowing the mode.

The add and compare paths use one byte-sliced carry chain that is cut at lane starts. The multiplier uses one shared array of byte-by-byte partial products, and the mode only chooses which of those products are summed. An operation is captured on a clock edge where the valid input is high, and the result appears one cycle later with the output valid flag set.

Top module: `packed_lane_alu`

## Requirements
- R1: `lane_mode` selects the lane width: 0 gives eight 8-bit lanes, 1 gives four 16-bit lanes, 2 gives two 32-bit lanes and 3 gives one 64-bit lane. Lane k takes operand bits starting at k times the lane width.
- R2: `op` selects the operation: 0 is add, 1 is multiply, and 2 or 3 is compare. For add, each result lane is (a + b) modulo 2^width, and no carry crosses a lane boundary.
- R3: For add, the carry flag of a lane is the carry out of that lane's top bit. For multiply and compare, every carry flag is 0.
- R4: For multiply, each result lane holds the low lane-width bits of the product of the two operand lanes.
- R5: For compare, each result lane is all ones when that lane's less-than flag is set, and all zeros otherwise.
- R6: For every operation, the equal flag of a lane is 1 exactly when the two operand lanes are identical.
- R7: For every operation, the less-than flag of a lane is set when a < b. The comparison is unsigned when `signed_cmp` is 0 and two's-complement when it is 1. The equal and less-than flags of a lane are never set together.
- R8: The zero flag of a lane is 1 when its result lane is all zeros. The sign flag of a lane equals the top bit of its result lane.
- R9: Bit i of every flag vector belongs to byte i. In wider modes, all byte positions of one lane carry the same flag value.
- R10: Inputs are captured on a rising edge where `in_valid` is 1. `out_valid` follows `in_valid` one cycle later. While `in_valid` is 0, the result and the flags hold their values.
- R11: A synchronous active-low reset clears `out_valid`, the result and all flags to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Capture the operation on this edge |
| lane_mode | input | 2 | Lane width select (0: 8, 1: 16, 2: 32, 3: 64 bits) |
| op | input | 2 | 0 add, 1 multiply, 2/3 compare |
| signed_cmp | input | 1 | Signed less-than when 1 |
| opa | input | 64 | Operand a |
| opb | input | 64 | Operand b |
| out_valid | output | 1 | Registered result is new |
| result | output | 64 | Packed lane results |
| flag_zero | output | 8 | Per-byte zero flag |
| flag_sign | output | 8 | Per-byte sign flag |
| flag_carry | output | 8 | Per-byte carry-out flag |
| flag_eq | output | 8 | Per-byte equal flag |
| flag_lt | output | 8 | Per-byte less-than flag |

## Verification
The bench builds the block with the default package widths: eight byte slices of eight bits each, which makes a 64-bit datapath. With these widths, all four lane modes can be reached through the `lane_mode` port, so a single build covers every lane boundary. That includes carry cuts at bytes 1, 2 and 4, and the signed compare at each lane's top bit. Directed operands such as all-ones plus one, and mixed signs in neighbouring lanes, are followed by a pseudo-random sweep over every mode, operation and signedness. Every result is compared against a lane-by-lane reference loop.

// File: rtl/plalu_pkg.sv
// Package: shared widths, codes and lane-spreading helpers for the packed ALU.
// Assumes the byte count is a power of two and at most 8 (2-bit mode field).
package plalu_pkg;
    localparam int NB     = 8;            // byte slices in the datapath
    localparam int BW     = 8;            // bits per byte slice
    localparam int DW     = NB * BW;      // datapath width
    localparam int MODE_W = 2;

    typedef enum logic [1:0] {
        OPC_ADD  = 2'd0,
        OPC_MUL  = 2'd1,
        OPC_CMP  = 2'd2,
        OPC_CMP2 = 2'd3
    } opcode_e;

    // True when byte i begins a lane for the given mode.
    function automatic logic is_lane_start(input int i, input logic [MODE_W-1:0] m);
        return (i & ((1 << m) - 1)) == 0;
    endfunction

    // AND all byte bits of each lane, copy the result to every byte of that lane.
    function automatic logic [NB-1:0] spread_and(input logic [NB-1:0] v,
                                                 input logic [MODE_W-1:0] m);
        logic [NB-1:0] r;
        int base;
        int span;
        logic all;
        span = 1 << m;
        for (int i = 0; i < NB; i++) begin
            base = (i >> m) << m;
            all  = 1'b1;
            for (int j = 0; j < NB; j++)
                if (j >= base && j < base + span) all &= v[j];
            r[i] = all;
        end
        return r;
    endfunction

    // Copy the top byte's bit of each lane onto every byte of that lane.
    function automatic logic [NB-1:0] spread_top(input logic [NB-1:0] v,
                                                 input logic [MODE_W-1:0] m);
        logic [NB-1:0] r;
        for (int i = 0; i < NB; i++)
            r[i] = v[((i >> m) << m) + (1 << m) - 1];
        return r;
    endfunction
endpackage

// File: rtl/lane_adder.sv
// Module: byte-sliced ripple adder whose carry chain restarts at every lane start.
// With do_sub=1 it forms a + ~b + 1, so the lane carry-out is the inverse of the borrow.
// Assumes lane_mode is one of the four legal codes.
module lane_adder
    import plalu_pkg::*;
(
    input  logic [DW-1:0]     a,
    input  logic [DW-1:0]     b,
    input  logic [MODE_W-1:0] lane_mode,
    input  logic              do_sub,
    output logic [DW-1:0]     sum,
    output logic [NB-1:0]     lane_cout
);
    logic [NB-1:0] byte_cout;

    // Purpose: ripple one carry through all byte slices, cutting it at lane starts.
    always_comb begin
        logic          cy;
        logic [BW-1:0] bop;
        logic [BW:0]   s;
        cy = 1'b0;
        for (int i = 0; i < NB; i++) begin
            if (is_lane_start(i, lane_mode)) cy = do_sub;
            bop = do_sub ? ~b[i*BW +: BW] : b[i*BW +: BW];
            s   = {1'b0, a[i*BW +: BW]} + {1'b0, bop} + {{BW{1'b0}}, cy};
            sum[i*BW +: BW] = s[BW-1:0];
            byte_cout[i]    = s[BW];
            cy              = s[BW];
        end
    end

    // Purpose: report each lane's carry-out from its top byte on all its bytes.
    always_comb lane_cout = spread_top(byte_cout, lane_mode);
endmodule

// File: rtl/lane_multiplier.sv
// Module: low-half packed multiplier built on one shared byte partial-product array.
// Each lane sums only the byte products that fall inside its own low half.
// Assumes lane_mode is one of the four legal codes.
module lane_multiplier
    import plalu_pkg::*;
(
    input  logic [DW-1:0]     a,
    input  logic [DW-1:0]     b,
    input  logic [MODE_W-1:0] lane_mode,
    output logic [DW-1:0]     prod
);
    logic [DW-1:0] acc [NB];

    // Purpose: gather the masked partial products into a per-lane accumulator.
    always_comb begin
        logic [2*BW-1:0] pp;
        int base;
        int off;
        for (int k = 0; k < NB; k++) acc[k] = '0;
        for (int i = 0; i < NB; i++) begin
            for (int j = 0; j < NB; j++) begin
                pp   = a[i*BW +: BW] * b[j*BW +: BW];
                base = (i >> lane_mode) << lane_mode;
                off  = (i - base) + (j - base);
                if ((i >> lane_mode) == (j >> lane_mode) && off < (1 << lane_mode))
                    acc[i >> lane_mode] = acc[i >> lane_mode]
                                        + (DW'(pp) << (BW * off));
            end
        end
    end

    // Purpose: place each lane's truncated accumulator into its byte positions.
    always_comb begin
        int base;
        for (int i = 0; i < NB; i++) begin
            base = (i >> lane_mode) << lane_mode;
            prod[i*BW +: BW] = acc[i >> lane_mode][(i - base)*BW +: BW];
        end
    end
endmodule

// File: rtl/packed_lane_alu.sv
// Module: top of the packed-lane ALU. Selects add/multiply/compare per lane,
// derives per-lane flags replicated per byte, and registers everything on in_valid.
// Assumes in_valid is held low during reset.
module packed_lane_alu
    import plalu_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [1:0]        lane_mode,
    input  logic [1:0]        op,
    input  logic              signed_cmp,
    input  logic [63:0]       opa,
    input  logic [63:0]       opb,
    output logic              out_valid,
    output logic [63:0]       result,
    output logic [7:0]        flag_zero,
    output logic [7:0]        flag_sign,
    output logic [7:0]        flag_carry,
    output logic [7:0]        flag_eq,
    output logic [7:0]        flag_lt
);
    opcode_e       opc;
    logic [DW-1:0] add_sum, sub_diff, mul_prod, cmp_res, nxt_res;
    logic [NB-1:0] add_cy, sub_cy, eq_b, a_top, b_top, zero_b, msb_b;
    logic [NB-1:0] lane_eq, lt_u, lt_s, lane_lt, nxt_zero, nxt_sign, nxt_carry;

    assign opc = opcode_e'(op);

    lane_adder u_add (.a(opa), .b(opb), .lane_mode(lane_mode), .do_sub(1'b0),
                      .sum(add_sum), .lane_cout(add_cy));
    lane_adder u_sub (.a(opa), .b(opb), .lane_mode(lane_mode), .do_sub(1'b1),
                      .sum(sub_diff), .lane_cout(sub_cy));
    lane_multiplier u_mul (.a(opa), .b(opb), .lane_mode(lane_mode), .prod(mul_prod));

    // Purpose: per-byte raw compare inputs gathered from the operands.
    always_comb begin
        for (int i = 0; i < NB; i++) begin
            eq_b[i]  = opa[i*BW +: BW] == opb[i*BW +: BW];
            a_top[i] = opa[i*BW + BW - 1];
            b_top[i] = opb[i*BW + BW - 1];
        end
    end

    // Purpose: lane equality and less-than from the subtract chain and sign bits.
    always_comb begin
        logic [NB-1:0] sa, sb;
        sa      = spread_top(a_top, lane_mode);
        sb      = spread_top(b_top, lane_mode);
        lane_eq = spread_and(eq_b, lane_mode);
        lt_u    = ~sub_cy;
        lt_s    = (sa & ~sb) | (~(sa ^ sb) & lt_u);
        lane_lt = signed_cmp ? lt_s : lt_u;
    end

    // Purpose: compare result mask and the operation result mux.
    always_comb begin
        for (int i = 0; i < NB; i++) cmp_res[i*BW +: BW] = {BW{lane_lt[i]}};
        unique case (opc)
            OPC_ADD: nxt_res = add_sum;
            OPC_MUL: nxt_res = mul_prod;
            default: nxt_res = cmp_res;
        endcase
    end

    // Purpose: zero, sign and carry flags of the selected result, per lane.
    always_comb begin
        for (int i = 0; i < NB; i++) begin
            zero_b[i] = nxt_res[i*BW +: BW] == '0;
            msb_b[i]  = nxt_res[i*BW + BW - 1];
        end
        nxt_zero  = spread_and(zero_b, lane_mode);
        nxt_sign  = spread_top(msb_b, lane_mode);
        nxt_carry = (opc == OPC_ADD) ? add_cy : '0;
    end

    // Purpose: output register, loaded only when a valid operation arrives.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            result     <= '0;
            flag_zero  <= '0;
            flag_sign  <= '0;
            flag_carry <= '0;
            flag_eq    <= '0;
            flag_lt    <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                result     <= nxt_res;
                flag_zero  <= nxt_zero;
                flag_sign  <= nxt_sign;
                flag_carry <= nxt_carry;
                flag_eq    <= lane_eq;
                flag_lt    <= lane_lt;
            end
        end
    end

    // Byte-lane add never takes a carry from below.
    assert_low_byte_isolated_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && lane_mode == 2'd0 && op == 2'd0)
        |=> result[7:0] == 8'($past(opa[7:0]) + $past(opb[7:0])));

    assert_no_carry_outside_add_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op != 2'd0) |=> flag_carry == '0);

    assert_eq_lt_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (flag_eq & flag_lt) == '0);

    assert_full_lane_replicated_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && lane_mode == 2'd3)
        |=> ((flag_eq == '0 || flag_eq == '1) && (flag_zero == '0 || flag_zero == '1)));

    assert_valid_latency_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> out_valid == $past(in_valid));

    assert_hold_when_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(result) && $stable(flag_lt)));
endmodule

// File: tb/sim_packed_lane_alu.sv
// Bench: directed scenarios plus a pseudo-random sweep against a lane-by-lane model.
module sim_packed_lane_alu;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [1:0]  lane_mode = '0;
    logic [1:0]  op = '0;
    logic        signed_cmp = 1'b0;
    logic [63:0] opa = '0, opb = '0;
    logic        out_valid;
    logic [63:0] result;
    logic [7:0]  flag_zero, flag_sign, flag_carry, flag_eq, flag_lt;
    int          n_checks = 0;
    int          n_errors = 0;
    logic [63:0] rng = 64'h9E37_79B9_7F4A_7C15;

    always #(CLK_PERIOD/2) clk = ~clk;

    packed_lane_alu u0 (.clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .lane_mode(lane_mode), .op(op), .signed_cmp(signed_cmp), .opa(opa), .opb(opb),
        .out_valid(out_valid), .result(result), .flag_zero(flag_zero),
        .flag_sign(flag_sign), .flag_carry(flag_carry), .flag_eq(flag_eq),
        .flag_lt(flag_lt));

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Reference: walk every lane with plain integer arithmetic.
    task automatic model(input logic [1:0] m, input logic [1:0] o, input logic sg,
                         input logic [63:0] a, input logic [63:0] b,
                         output logic [63:0] r, output logic [7:0] z, output logic [7:0] s,
                         output logic [7:0] c, output logic [7:0] e, output logic [7:0] l);
        int span = 1 << m;
        int w = 8 * span;
        logic [63:0] mask = (w == 64) ? '1 : ((64'd1 << w) - 1);
        r = '0; z = '0; s = '0; c = '0; e = '0; l = '0;
        for (int k = 0; k < 8 / span; k++) begin
            logic [63:0] al, bl, res;
            logic [64:0] sm;
            logic lt, cy;
            al = (a >> (k * w)) & mask;
            bl = (b >> (k * w)) & mask;
            sm = {1'b0, al} + {1'b0, bl};
            cy = sm[w];
            if (sg && (al[w-1] != bl[w-1])) lt = al[w-1];
            else lt = al < bl;
            if (o == 2'd0)      res = sm[63:0] & mask;
            else if (o == 2'd1) res = (al * bl) & mask;
            else                res = lt ? mask : '0;
            r |= res << (k * w);
            for (int j = k * span; j < (k + 1) * span; j++) begin
                z[j] = (res == 0);
                s[j] = res[w-1];
                c[j] = (o == 2'd0) ? cy : 1'b0;
                e[j] = (al == bl);
                l[j] = lt;
            end
        end
    endtask

    // Issue one operation, then check every output against the model.
    task automatic run_op(input string tag, input logic [1:0] m, input logic [1:0] o,
                          input logic sg, input logic [63:0] a, input logic [63:0] b);
        logic [63:0] r;
        logic [7:0] z, s, c, e, l;
        model(m, o, sg, a, b, r, z, s, c, e, l);
        @(negedge clk);
        lane_mode = m; op = o; signed_cmp = sg; opa = a; opb = b; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        chk({tag, " result"}, result, r);
        chk({tag, " zero"}, 64'(flag_zero), 64'(z));
        chk({tag, " sign"}, 64'(flag_sign), 64'(s));
        chk({tag, " carry"}, 64'(flag_carry), 64'(c));
        chk({tag, " eq"}, 64'(flag_eq), 64'(e));
        chk({tag, " lt"}, 64'(flag_lt), 64'(l));
    endtask

    task automatic test_reset;
        chk("R11 out_valid", 64'(out_valid), 64'd0);
        chk("R11 result", result, 64'd0);
        chk("R11 flags", {24'd0, flag_zero, flag_sign, flag_carry, flag_eq, flag_lt}, 64'd0);
    endtask

    task automatic test_add;
        run_op("R2 R3 add8 carry cut", 2'd0, 2'd0, 1'b0, 64'hFF01_FF80_00FF_7F10, 64'h0101_0180_0001_0120);
        chk("R2 add8 byte0", result[7:0], 8'h30);
        run_op("R2 add16", 2'd1, 2'd0, 1'b0, 64'hFFFF_0000_FFFF_1234, 64'h0001_0000_0002_0001);
        run_op("R2 add32", 2'd2, 2'd0, 1'b0, 64'hFFFF_FFFF_0000_0001, 64'h0000_0001_FFFF_FFFF);
        run_op("R1 add64 wrap", 2'd3, 2'd0, 1'b0, '1, 64'd1);
        chk("R3 add64 carry", 64'(flag_carry), 64'hFF);
    endtask

    task automatic test_mul;
        run_op("R4 mul8", 2'd0, 2'd1, 1'b0, 64'hFF10_0302_8001_0F11, 64'hFF10_0505_0203_1111);
        chk("R4 mul8 byte7", result[63:56], 8'h01);
        run_op("R4 mul16", 2'd1, 2'd1, 1'b0, 64'hFFFF_1234_0100_00FF, 64'hFFFF_0010_0100_00FF);
        run_op("R4 mul32", 2'd2, 2'd1, 1'b0, 64'h1234_5678_FFFF_FFFF, 64'h0000_1000_0000_0002);
        run_op("R4 mul64", 2'd3, 2'd1, 1'b0, 64'h0123_4567_89AB_CDEF, 64'hFEDC_BA98_7654_3210);
    endtask

    task automatic test_cmp;
        run_op("R5 R6 R7 cmp8 unsigned", 2'd0, 2'd2, 1'b0, 64'h80FF_0102_0505_7F00, 64'h7F00_0201_0506_8000);
        run_op("R7 cmp8 signed", 2'd0, 2'd2, 1'b1, 64'h80FF_0102_0505_7F00, 64'h7F00_0201_0506_8000);
        chk("R7 signed byte7 lt", 64'(flag_lt[7]), 64'd1);
        run_op("R7 cmp16 signed code3", 2'd1, 2'd3, 1'b1, 64'hFFFF_0001_8000_1234, 64'h0001_FFFF_8000_1235);
        run_op("R6 cmp64 equal", 2'd3, 2'd2, 1'b0, 64'hDEAD_BEEF_0000_0001, 64'hDEAD_BEEF_0000_0001);
        chk("R6 cmp64 eq all bytes", 64'(flag_eq), 64'hFF);
    endtask

    task automatic test_flags;
        run_op("R8 R9 zero/sign32", 2'd2, 2'd0, 1'b0, 64'h7FFF_FFFF_0000_0001, 64'h0000_0001_FFFF_FFFF);
        chk("R9 zero upper/lower", 64'({flag_zero, flag_sign}), 64'h0FF0);
    endtask

    task automatic test_hold;
        logic [63:0] keep;
        keep = result;
        @(negedge clk);
        opa = 64'h1111_1111_1111_1111; opb = 64'h2222_2222_2222_2222; op = 2'd0;
        @(negedge clk);
        chk("R10 out_valid low", 64'(out_valid), 64'd0);
        chk("R10 result held", result, keep);
        @(negedge clk);
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        chk("R10 out_valid high", 64'(out_valid), 64'd1);
    endtask

    task automatic test_sweep;
        for (int it = 0; it < 60; it++) begin
            logic [63:0] a, b;
            rng ^= rng << 13; rng ^= rng >> 7; rng ^= rng << 17; a = rng;
            rng ^= rng << 13; rng ^= rng >> 7; rng ^= rng << 17; b = rng;
            if (it % 5 == 0) b = a;
            run_op("R1 R2 R4 R5 R7 sweep", 2'(it % 4), 2'((it / 4) % 4), it[0] ^ it[3], a, b);
        end
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_checks++; n_errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        test_reset;
        rst_n = 1'b1;
        test_add;
        test_mul;
        test_cmp;
        test_flags;
        test_hold;
        test_sweep;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule